// File: doc/BRIEF.md
# Majority-Vote Register Read Sampler

This block stands between a requester and a slow register interface whose read data can be corrupted. The requester asks for one register offset. The block then reads that offset a fixed number of times, one read after another, and returns the value that came back most often. A value that appears only on a few reads cannot reach the requester unless no other value appears more often.

Each read response goes into a table of distinct values, and each value in the table keeps its own occurrence count. A value already in the table adds one to its count. A value not yet seen is added at the next free slot with a count of one. When all reads are back, the block scans the table in slot order and keeps the first entry with the highest count. It then raises done for one cycle and holds the selected value on its result output.

The register side allows one read in flight at a time. The block sends a one-cycle strobe with the address. The read data is taken only in the cycle in which the acknowledge is high. The table is cleared each time a request is accepted.

Top module: `majority_read_sampler`

## Requirements
- R1: `req_ready_o` is high only while the block is idle. A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. From that edge on, `req_ready_o` stays low up to and including the cycle in which `done_o` is high.
- R2: Each accepted request produces exactly NUM_SAMPLES read strobes (100 by default). Each strobe lasts one cycle. The first strobe comes in the cycle after acceptance. Each later strobe comes in the cycle after the acknowledge of the previous read.
- R3: The offset on `req_addr_i` is captured on the acceptance edge, and every strobe of that request carries it on `rd_addr_o`. Changes on `req_addr_i`, and `req_valid_i` held high while busy, have no effect on that request.
- R4: `result_o` is the value that occurred most often among the NUM_SAMPLES acknowledged read values.
- R5: When two or more values share the highest count, `result_o` is the one whose first occurrence came earliest. This holds even if another tied value reached that count sooner or is numerically smaller.
- R6: When all NUM_SAMPLES values are distinct, `result_o` is the first value read.
- R7: When all NUM_SAMPLES values are equal, `result_o` is that value.
- R8: `done_o` is high for exactly one cycle. With K distinct values in the sample set, it appears K+1 cycles after the cycle in which the final acknowledge was presented.
- R9: `result_o` changes only in the cycle in which `done_o` is high, and otherwise stays stable. This includes the idle time between requests. An acknowledge that arrives while no read is outstanding has no effect.
- R10: The distinct-value table starts empty for every request. Values seen in an earlier request do not affect a later result.
- R11: After synchronous reset, `req_ready_o` is 1, and `rd_stb_o`, `done_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Requester asks for a voted read |
| req_addr_i | input | ADDR_W | Register offset to read |
| req_ready_o | output | 1 | Block is idle and can accept a request |
| done_o | output | 1 | One-cycle pulse when the result is available |
| result_o | output | DATA_W | Most frequent read value, held until the next done |
| rd_stb_o | output | 1 | One-cycle read strobe to the register side |
| rd_addr_o | output | ADDR_W | Offset sent with the strobe |
| rd_ack_i | input | 1 | Read data is valid this cycle |
| rd_data_i | input | DATA_W | Read data from the register side |

## Verification
A wrong count or a wrong slot in the table cannot be seen at the ports while sampling runs. It first shows in the value of `result_o` when `done_o` rises. It can also shift the cycle of `done_o`, because the scan takes one cycle per distinct value. For that reason each test pattern is chosen so that a faulty match, a faulty append, a tie resolved the wrong way or a table left uncleared would select a different value.

Faults in the sequencing show up at once. A missing or extra strobe, a strobe in the wrong cycle, or a wrong address is visible in the same cycle. This is because the reference model predicts every strobe and every done pulse to the exact cycle.

// File: rtl/mrs_pkg.sv
// Package: shared types for the majority-vote read sampler.
// Assumes: nothing beyond the IEEE 1800-2017 type system.
package mrs_pkg;

    // Phases of one voted read
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SCAN  = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/mrs_value_table.sv
// Module: distinct-value table with one occurrence counter per entry.
// Compares an inserted sample against every occupied entry in parallel. On a
// match it increments that entry's count; otherwise it appends the sample at
// the next free slot with a count of one. Entries are addressed for readout by
// slot index, in order of first appearance.
// Assumes: the caller never inserts more than DEPTH samples between clears,
// and clear and insert are never high in the same cycle.
module mrs_value_table #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 100,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              ins_i,
    input  logic [DATA_W-1:0] ins_data_i,
    input  logic [CNT_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_val_o,
    output logic [CNT_W-1:0]  rd_cnt_o,
    output logic [CNT_W-1:0]  used_o
);

    logic [DATA_W-1:0] val_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q [DEPTH];
    logic [CNT_W-1:0]  used_q;
    logic [DEPTH-1:0]  match;
    logic              hit;

    // Per-slot comparator: an occupied slot holding the same value
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = (CNT_W'(g) < used_q) && (val_q[g] == ins_data_i);
    end

    // Any slot already holds the sample
    assign hit = |match;

    // Slot contents: increment the matching count or append a new value
    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (!rst_n || clr_i) begin
                cnt_q[k] <= '0;
            end else if (ins_i) begin
                if (match[k]) begin
                    cnt_q[k] <= cnt_q[k] + 1'b1;
                end else if (!hit && (used_q == CNT_W'(k))) begin
                    val_q[k] <= ins_data_i;
                    cnt_q[k] <= CNT_W'(1);
                end
            end
        end
    end

    // Occupancy: grows by one per previously unseen value
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            used_q <= '0;
        end else if (ins_i && !hit) begin
            used_q <= used_q + 1'b1;
        end
    end

    assign rd_val_o = val_q[rd_idx_i];
    assign rd_cnt_o = cnt_q[rd_idx_i];
    assign used_o   = used_q;

    // R4
    table_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_i && !hit) |-> (used_q < CNT_W'(DEPTH)));

    // R4
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_i |-> $onehot0(match));

endmodule

// File: rtl/mrs_mode_picker.sv
// Module: sequential scan that selects the entry with the highest count.
// While active it visits slot 0 up to used_i-1, one slot per cycle. The running
// best is replaced only on a strictly greater count, so among equal counts the
// earliest slot wins. finish_o marks the cycle of the last slot, and best_o
// then gives the final winner, including that slot.
// Assumes: used_i is at least 1 and does not change while active_i is high.
module mrs_mode_picker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic [CNT_W-1:0]  used_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CNT_W-1:0]  idx_o,
    output logic              finish_o,
    output logic [DATA_W-1:0] best_o
);

    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  best_cnt_q;
    logic [DATA_W-1:0] best_val_q;
    logic              take;

    // Strictly greater count replaces the current best
    assign take     = cnt_i > best_cnt_q;
    assign finish_o = active_i && (idx_q == used_i - CNT_W'(1));
    assign best_o   = take ? val_i : best_val_q;
    assign idx_o    = idx_q;

    // Scan position and running best; restarts whenever inactive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            best_cnt_q <= '0;
            best_val_q <= '0;
        end else if (!active_i) begin
            idx_q      <= '0;
            best_cnt_q <= '0;
        end else begin
            idx_q <= idx_q + 1'b1;
            if (take) begin
                best_cnt_q <= cnt_i;
                best_val_q <= val_i;
            end
        end
    end

    // R8
    scan_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (idx_q < used_i));

endmodule

// File: rtl/mrs_sequencer.sv
// Module: control for one voted read.
// Accepts a request, latches its offset, issues NUM_SAMPLES one-cycle read
// strobes (each after the previous acknowledge), feeds every acknowledged value
// into the table, runs the mode scan, registers the winner and pulses done.
// Assumes: the register side answers every strobe with exactly one acknowledge,
// no earlier than the cycle after the strobe.
module mrs_sequencer
    import mrs_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int NUM_SAMPLES = 100,
    parameter int CNT_W       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic              rd_stb_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              tbl_clr_o,
    output logic              tbl_ins_o,
    output logic [DATA_W-1:0] tbl_data_o,
    output logic              scan_active_o,
    input  logic              scan_finish_i,
    input  logic [DATA_W-1:0] scan_best_i
);

    localparam logic [CNT_W-1:0] LAST_SMP = CNT_W'(NUM_SAMPLES - 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  smp_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] result_q;
    logic              accept;
    logic              take_ack;

    assign accept   = (state_q == ST_IDLE) && req_valid_i;
    assign take_ack = (state_q == ST_WAIT) && rd_ack_i;

    // Next phase of the voted read
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid_i) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (rd_ack_i) state_d = (smp_q == LAST_SMP) ? ST_SCAN : ST_ISSUE;
            ST_SCAN:  if (scan_finish_i) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Offset latched once per request
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= req_addr_i;
    end

    // Count of acknowledged samples in this request
    always_ff @(posedge clk) begin
        if (!rst_n)        smp_q <= '0;
        else if (accept)   smp_q <= '0;
        else if (take_ack) smp_q <= smp_q + 1'b1;
    end

    // Result register, loaded only when the scan ends
    always_ff @(posedge clk) begin
        if (!rst_n)                                  result_q <= '0;
        else if (state_q == ST_SCAN && scan_finish_i) result_q <= scan_best_i;
    end

    assign req_ready_o   = (state_q == ST_IDLE);
    assign rd_stb_o      = (state_q == ST_ISSUE);
    assign rd_addr_o     = addr_q;
    assign done_o        = (state_q == ST_DONE);
    assign result_o      = result_q;
    assign tbl_clr_o     = accept;
    assign tbl_ins_o     = take_ack;
    assign tbl_data_o    = rd_data_i;
    assign scan_active_o = (state_q == ST_SCAN);

    // R2
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_o |=> !rd_stb_o);

    // R2
    sample_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (smp_q <= LAST_SMP));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready_o && !$past(req_ready_o)) |-> $stable(rd_addr_o));

endmodule

// File: rtl/majority_read_sampler.sv
// Module: top of the majority-vote register read sampler.
// Wires the sequencer, the distinct-value table and the mode picker together.
// The table readout port is shared by the picker's scan index.
// Assumes: one read outstanding at a time on the register side.
module majority_read_sampler #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int NUM_SAMPLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic              rd_stb_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i
);

    localparam int CNT_W = $clog2(NUM_SAMPLES + 1);

    logic              tbl_clr;
    logic              tbl_ins;
    logic [DATA_W-1:0] tbl_data;
    logic [CNT_W-1:0]  tbl_used;
    logic [DATA_W-1:0] tbl_val;
    logic [CNT_W-1:0]  tbl_cnt;
    logic [CNT_W-1:0]  scan_idx;
    logic              scan_active;
    logic              scan_finish;
    logic [DATA_W-1:0] scan_best;

    mrs_sequencer #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .NUM_SAMPLES(NUM_SAMPLES), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .req_ready_o(req_ready_o), .done_o(done_o), .result_o(result_o),
        .rd_stb_o(rd_stb_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .tbl_clr_o(tbl_clr), .tbl_ins_o(tbl_ins), .tbl_data_o(tbl_data),
        .scan_active_o(scan_active), .scan_finish_i(scan_finish),
        .scan_best_i(scan_best)
    );

    mrs_value_table #(
        .DATA_W(DATA_W), .DEPTH(NUM_SAMPLES), .CNT_W(CNT_W)
    ) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .clr_i(tbl_clr), .ins_i(tbl_ins), .ins_data_i(tbl_data),
        .rd_idx_i(scan_idx), .rd_val_o(tbl_val), .rd_cnt_o(tbl_cnt),
        .used_o(tbl_used)
    );

    mrs_mode_picker #(
        .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_pick (
        .clk(clk), .rst_n(rst_n),
        .active_i(scan_active), .used_i(tbl_used),
        .val_i(tbl_val), .cnt_i(tbl_cnt),
        .idx_o(scan_idx), .finish_o(scan_finish), .best_o(scan_best)
    );

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R1
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

endmodule

// File: tb/test_majority_read_sampler.sv
`timescale 1ns/100ps
module test_majority_read_sampler;

    localparam int N = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [7:0]  req_addr_i = '0;
    logic        req_ready_o;
    logic        done_o;
    logic [31:0] result_o;
    logic        rd_stb_o;
    logic [7:0]  rd_addr_o;
    logic        rd_ack_i = 1'b0;
    logic [31:0] rd_data_i = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [31:0] pat [N];

    always #2.5 clk = ~clk;

    majority_read_sampler i_majority_read_sampler (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .req_ready_o(req_ready_o), .done_o(done_o), .result_o(result_o),
        .rd_stb_o(rd_stb_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Behavioural mode: first-seen order, strictly greater count wins
    task automatic model(output logic [31:0] expv, output int used);
        logic [31:0] dv[$];
        int dc[$];
        int bestc;
        for (int k = 0; k < N; k++) begin
            int f;
            f = -1;
            for (int m = 0; m < dv.size(); m++) if (dv[m] == pat[k]) f = m;
            if (f < 0) begin dv.push_back(pat[k]); dc.push_back(1); end
            else dc[f] = dc[f] + 1;
        end
        bestc = 0;
        expv = '0;
        for (int m = 0; m < dv.size(); m++) if (dc[m] > bestc) begin bestc = dc[m]; expv = dv[m]; end
        used = dv.size();
    endtask

    // One voted read, compared against the cycle model on every negedge
    task automatic run_req(input logic [7:0] a, input int dmode, input string tag);
        int stb_due, ack_due, issued, acked, done_due, cyc, used;
        logic [31:0] expv;
        model(expv, used);
        chk(req_ready_o === 1'b1, "R1", 32'(req_ready_o), 32'd1);
        req_valid_i = 1'b1;
        req_addr_i  = a;
        stb_due = 1; ack_due = -1; done_due = -1; issued = 0; acked = 0; cyc = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            rd_ack_i   = 1'b0;
            rd_data_i  = 32'hBAD0_0000 ^ 32'(cyc);
            req_addr_i = a ^ 8'h5A ^ cyc[7:0];           // R3 noise while busy
            chk(rd_stb_o === (cyc == stb_due), "R2 strobe timing", 32'(rd_stb_o), 32'(cyc == stb_due));
            if (rd_stb_o) chk(rd_addr_o === a, "R3 address", 32'(rd_addr_o), 32'(a));
            chk(req_ready_o === 1'b0, "R1 busy", 32'(req_ready_o), 32'd0);
            chk(done_o === (cyc == done_due), "R8 done timing", 32'(done_o), 32'(cyc == done_due));
            if (rd_stb_o) begin
                ack_due = cyc + ((dmode == 0) ? 1 : (issued % 4) + 1);
                issued++;
            end
            if (cyc == ack_due) begin
                rd_ack_i  = 1'b1;
                rd_data_i = pat[acked];
                acked++;
                if (acked < N) stb_due = cyc + 1;
                else           done_due = cyc + used + 1;
            end
            if (done_o) begin
                chk(result_o === expv, tag, result_o, expv);
                break;
            end
            if (cyc > 4000) begin
                chk(1'b0, "R8 no done", 32'(cyc), 32'(done_due));
                break;
            end
        end
        req_valid_i = 1'b0;
        chk(issued == N, "R2 strobe count", 32'(issued), 32'(N));
        @(negedge clk);
        chk(req_ready_o === 1'b1, "R1 ready after done", 32'(req_ready_o), 32'd1);
        chk(done_o === 1'b0, "R8 single pulse", 32'(done_o), 32'd0);
        chk(result_o === expv, "R9 hold", result_o, expv);
    endtask

    // Idle cycles with stray acknowledges: nothing may move
    task automatic idle_check(input int n, input logic [31:0] held);
        for (int i = 0; i < n; i++) begin
            rd_ack_i  = i[0];
            rd_data_i = 32'h7777_0000 + 32'(i);
            @(negedge clk);
            chk(result_o === held, "R9 stray ack", result_o, held);
            chk(done_o === 1'b0 && rd_stb_o === 1'b0, "R9 idle quiet", {30'd0, done_o, rd_stb_o}, 32'd0);
        end
        rd_ack_i = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(req_ready_o === 1'b1, "R11 ready", 32'(req_ready_o), 32'd1);
        chk(rd_stb_o === 1'b0, "R11 strobe", 32'(rd_stb_o), 32'd0);
        chk(done_o === 1'b0, "R11 done", 32'(done_o), 32'd0);
        chk(result_o === 32'd0, "R11 result", result_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: one dominant value among several others
        for (int i = 0; i < N; i++) pat[i] = (i % 9 < 5) ? 32'hCAFE_0001 : 32'hA000_0000 + 32'(i % 9);
        run_req(8'h0C, 0, "R4 majority");
        idle_check(5, 32'hCAFE_0001);

        // R5: tie, earliest first-seen wins although it is larger and reaches 50 first only by order
        for (int i = 0; i < N; i++) pat[i] = i[0] ? 32'h1000_0000 : 32'h9000_0000;
        run_req(8'h1C, 1, "R5 tie");

        // R5: tie where the later value reaches the top count first
        for (int i = 0; i < N; i++) pat[i] = (i == 0 || i >= 51) ? 32'h0000_00AA : 32'h0000_0011;
        run_req(8'h20, 0, "R5 late first");

        // R6: all distinct
        for (int i = 0; i < N; i++) pat[i] = 32'h0000_0100 + 32'(i) * 7;
        run_req(8'hFF, 1, "R6 all distinct");

        // R7: all equal
        for (int i = 0; i < N; i++) pat[i] = 32'hDEAD_BEEF;
        run_req(8'h00, 0, "R7 all equal");
        idle_check(3, 32'hDEAD_BEEF);

        // R10: previous value absent; stale table would return DEADBEEF
        for (int i = 0; i < N; i++) pat[i] = (i < 30) ? 32'h0E0E_0E0E : (i < 75) ? 32'h0F0F_0F0F : 32'h1234_5678;
        run_req(8'h44, 1, "R10 cleared table");

        summary();
    end

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        summary();
    end

endmodule